// File: doc/BRIEF.md
# Scan-Loaded Fault Injection Engine

This block evaluates how a small built-in sequential circuit reacts to single-event upsets. Each fault is given as a complete faulty register state together with the stimulus cycle at which that state applies. The state is usually the fault-free state at that cycle with one bit inverted. The circuit's registers form a shift chain. For each fault, the engine freezes the circuit, shifts the stored state in one bit per clock, and then resumes normal clocking with the stimulus sequence from the stored cycle onward. The engine classifies the fault as a failure if the outputs differ from a reference before the sequence ends. Otherwise the fault is classed as having no effect.

A campaign starts with a pulse on `start`. The engine first performs one reference run from the circuit's initial state and keeps the output of every cycle in an internal reference store. It then works through every fault record in index order. Fault records are written through a simple write port while the engine is idle. At the end, `done` is raised and the outcome of every record is shown as one bit per record. The stimulus is produced inside the block from the cycle number, so a campaign needs no host traffic between its start and its end.

Top module: `ssfi_engine`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `scan_active` are low and `fail_map` is all zeros.
- R2: A `start` pulse accepted while idle or done reloads the circuit state with INIT and runs NCYC reference cycles. Cycle t applies the stimulus (t*STIM_K) mod 2^W and records the circuit output of that cycle as the reference.
- R3: On a functional clock, the circuit state s becomes ({s[W-2:0],0} xor stimulus xor (s[W-1] ? POLY : 0)). The circuit output is s[OW-1:0].
- R4: For each record, `scan_active` stays high for exactly W consecutive cycles and the circuit does not take functional clocks during that time. Bit j of the record state is shifted in at step j (least significant bit first), so after the last shift the circuit state equals the record state.
- R5: A record is written as `rec_wdata` = {cycle, state}. The state occupies bits [W-1:0] and the cycle index occupies bits [W+CW-1:W], where CW = clog2(NCYC)+1.
- R6: After the shift, replay starts at the record's cycle c. For each t = c..NCYC-1, the engine compares the output against the reference of cycle t, then clocks the circuit with stimulus t. The first mismatch ends the replay and marks the record as a failure (bit value 1).
- R7: A record with no mismatch up to the end of the sequence is marked as no-effect (bit value 0). This includes a record whose cycle index is NCYC or more.
- R8: Records are processed in order 0..NREC-1, and `fail_map[i]` holds the outcome of record i. After the last record, `done` rises and stays high with `busy` low until the next `start`. An accepted `start` clears `fail_map` on the following cycle.
- R9: Record writes presented while `busy` is high are ignored.
- R10: `start` while `busy` is high is ignored, so the campaign length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a campaign (reference run, then all records) |
| rec_we | input | 1 | Write strobe for the fault record store |
| rec_addr | input | clog2(NREC) | Record index to write |
| rec_wdata | input | CW+W | Record {cycle, state} |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | All records classified |
| scan_active | output | 1 | Circuit frozen while a state is shifted in |
| fail_map | output | NREC | Per-record outcome, 1 = failure |

## Verification
The bench uses the default parameters: an 8-bit circuit with a 4-bit output, a 16-cycle stimulus and 8 records. These sizes make it possible to place faults in the first cycle, in the last cycle and beyond the end of the sequence. They also allow injection of a state equal to the fault-free one, and a flip of every state bit at a single cycle. With a high-bit flip, the error is hidden from the output for some cycles before the feedback term reveals it, so both early and late failures can occur. The bench checks the exact number of busy cycles against a model that ends each replay at its first mismatch. This catches replays that do not stop early, and restarts caused by a `start` during a campaign.

// File: rtl/ssfi_pkg.sv
package ssfi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GOLD  = 3'd1,
    ST_FETCH = 3'd2,
    ST_SHIFT = 3'd3,
    ST_RUN   = 3'd4,
    ST_LOG   = 3'd5,
    ST_DONE  = 3'd6
  } ssfi_state_e;

endpackage

// File: rtl/ssfi_cut.sv
// Circuit under test: a small feedback shift register whose flops double
// as a serial load chain. Functional clocking and shifting are exclusive.
module ssfi_cut #(
  parameter int W = 8,
  parameter int OW = 4,
  parameter logic [W-1:0] INIT = '0,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_en,
  input  logic          func_en,
  input  logic          scan_en,
  input  logic          scan_in,
  input  logic [W-1:0]  stim,
  output logic [OW-1:0] dout
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic [W-1:0] fb;
  logic         st_en;

  always_comb begin
    fb    = st_q[W-1] ? POLY : '0;
    st_en = init_en | func_en | scan_en;
    if (init_en) begin
      st_d = INIT;
    end else if (scan_en) begin
      st_d = {scan_in, st_q[W-1:1]};
    end else begin
      st_d = {st_q[W-2:0], 1'b0} ^ stim ^ fb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= INIT;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign dout = st_q[OW-1:0];

  // R4: scan shifting and functional clocking never overlap
  a_r4_scan_func_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(func_en && scan_en));

  // R4: with no enable active the circuit holds its state
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_en && !func_en && !scan_en) |=> $stable(st_q));

endmodule

// File: rtl/ssfi_recmem.sv
// Fault record store: synchronous write, combinational read.
module ssfi_recmem #(
  parameter int NREC = 8,
  parameter int RW = 13
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREC)-1:0] waddr,
  input  logic [RW-1:0]           wdata,
  input  logic [$clog2(NREC)-1:0] raddr,
  output logic [RW-1:0]           rdata
);

  logic [RW-1:0] mem [NREC];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ssfi_goldmem.sv
// Reference output store, one entry per stimulus cycle.
module ssfi_goldmem #(
  parameter int NCYC = 16,
  parameter int OW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [OW-1:0] wdata,
  input  logic [CW-1:0] raddr,
  output logic [OW-1:0] rdata
);

  localparam int GAW = $clog2(NCYC);

  logic [OW-1:0] mem [NCYC];
  logic          rd_ok;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr[GAW-1:0]] <= wdata;
    end
  end

  assign rd_ok = raddr < CW'(NCYC);
  assign rdata = rd_ok ? mem[raddr[GAW-1:0]] : '0;

  // R2: the reference run writes only inside the stimulus window
  a_r2_gold_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < CW'(NCYC)));

endmodule

// File: rtl/ssfi_ctrl.sv
// Campaign sequencer: reference run, then fetch / shift / replay / log
// for every record.
module ssfi_ctrl
  import ssfi_pkg::*;
#(
  parameter int W = 8,
  parameter int OW = 4,
  parameter int NCYC = 16,
  parameter int NREC = 8,
  parameter int CW = 5,
  parameter logic [W-1:0] STIM_K = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CW+W-1:0]         rec_rdata,
  output logic [$clog2(NREC)-1:0] rec_raddr,
  output logic                    gold_we,
  output logic [CW-1:0]           gold_addr,
  input  logic [OW-1:0]           gold_rdata,
  input  logic [OW-1:0]           cut_dout,
  output logic                    cut_init,
  output logic                    cut_func,
  output logic                    cut_scan,
  output logic                    cut_scan_in,
  output logic [W-1:0]            stim,
  output logic                    busy,
  output logic                    done,
  output logic [NREC-1:0]         fail_map
);

  localparam int AW = $clog2(NREC);
  localparam int BW = $clog2(W);
  localparam int RW = CW + W;

  ssfi_state_e    st_q, st_d;
  logic [CW-1:0]  t_q, t_d;
  logic [AW-1:0]  idx_q, idx_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic [W-1:0]   sh_q, sh_d;
  logic           fail_q, fail_d;
  logic [NREC-1:0] map_q, map_d;
  logic           t_en, sh_en, map_en;
  logic           in_range;
  logic           mismatch;
  logic [W-1:0]   t_w;

  assign t_w      = W'(t_q);
  assign stim     = t_w * STIM_K;
  assign in_range = t_q < CW'(NCYC);
  assign mismatch = cut_dout != gold_rdata;

  always_comb begin
    st_d        = st_q;
    t_d         = t_q;
    idx_d       = idx_q;
    bit_d       = bit_q;
    sh_d        = sh_q;
    fail_d      = fail_q;
    map_d       = map_q;
    t_en        = 1'b0;
    sh_en       = 1'b0;
    map_en      = 1'b0;
    cut_init    = 1'b0;
    cut_func    = 1'b0;
    cut_scan    = 1'b0;
    cut_scan_in = sh_q[0];
    gold_we     = 1'b0;
    rec_raddr   = idx_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          cut_init = 1'b1;
          t_d      = '0;
          t_en     = 1'b1;
          map_d    = '0;
          map_en   = 1'b1;
          st_d     = ST_GOLD;
        end
      end
      ST_GOLD: begin
        gold_we  = 1'b1;
        cut_func = 1'b1;
        t_d      = t_q + 1'b1;
        t_en     = 1'b1;
        if (t_q == CW'(NCYC - 1)) begin
          idx_d = '0;
          st_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        sh_d   = rec_rdata[W-1:0];
        sh_en  = 1'b1;
        t_d    = rec_rdata[RW-1:W];
        t_en   = 1'b1;
        bit_d  = '0;
        fail_d = 1'b0;
        st_d   = ST_SHIFT;
      end
      ST_SHIFT: begin
        cut_scan = 1'b1;
        sh_d     = sh_q >> 1;
        sh_en    = 1'b1;
        bit_d    = bit_q + 1'b1;
        if (bit_q == BW'(W - 1)) begin
          st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!in_range) begin
          st_d = ST_LOG;
        end else if (mismatch) begin
          fail_d = 1'b1;
          st_d   = ST_LOG;
        end else begin
          cut_func = 1'b1;
          t_d      = t_q + 1'b1;
          t_en     = 1'b1;
        end
      end
      ST_LOG: begin
        map_d[idx_q] = fail_q;
        map_en       = 1'b1;
        if (idx_q == AW'(NREC - 1)) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign gold_addr = t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      t_q    <= '0;
      idx_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      fail_q <= 1'b0;
      map_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
      fail_q <= fail_d;
      if (t_en)   t_q   <= t_d;
      if (sh_en)  sh_q  <= sh_d;
      if (map_en) map_q <= map_d;
    end
  end

  assign busy     = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done     = st_q == ST_DONE;
  assign fail_map = map_q;

  // Length of the current shift window, for the check below.
  logic [BW:0] scan_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_run_q <= '0;
    end else if (cut_scan) begin
      scan_run_q <= scan_run_q + 1'b1;
    end else begin
      scan_run_q <= '0;
    end
  end

  // R4: each shift window is exactly W cycles long
  a_r4_scan_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cut_scan) |-> (scan_run_q == (BW+1)'(W)));

  // R10: a campaign in flight is never restarted
  a_r10_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cut_init);

  // R8: done holds until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8: the outcome map is frozen while done stays high
  a_r8_map_stable_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(fail_map));

endmodule

// File: rtl/ssfi_engine.sv
// Top: record store, reference store, circuit under test and sequencer.
module ssfi_engine #(
  parameter int W = 8,
  parameter int OW = 4,
  parameter int NCYC = 16,
  parameter int NREC = 8,
  parameter logic [W-1:0] INIT = 8'h5A,
  parameter logic [W-1:0] POLY = 8'h1D,
  parameter logic [W-1:0] STIM_K = 8'h13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          rec_we,
  input  logic [$clog2(NREC)-1:0]       rec_addr,
  input  logic [$clog2(NCYC)+W:0]       rec_wdata,
  output logic                          busy,
  output logic                          done,
  output logic                          scan_active,
  output logic [NREC-1:0]               fail_map
);

  localparam int CW = $clog2(NCYC) + 1;
  localparam int AW = $clog2(NREC);
  localparam int RW = CW + W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [AW-1:0] rec_raddr;
  logic [RW-1:0] rec_rdata;
  logic          rec_wr_ok;
  logic          gold_we;
  logic [CW-1:0] gold_addr;
  logic [OW-1:0] gold_rdata;
  logic [OW-1:0] cut_dout;
  logic          cut_init, cut_func, cut_scan, cut_scan_in;
  logic [W-1:0]  stim;

  assign rec_wr_ok = rec_we & ~busy;

  ssfi_recmem #(.NREC(NREC), .RW(RW)) u_recmem (
    .clk   (clk),
    .we    (rec_wr_ok),
    .waddr (rec_addr),
    .wdata (rec_wdata),
    .raddr (rec_raddr),
    .rdata (rec_rdata)
  );

  ssfi_goldmem #(.NCYC(NCYC), .OW(OW), .CW(CW)) u_goldmem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (gold_we),
    .waddr (gold_addr),
    .wdata (cut_dout),
    .raddr (gold_addr),
    .rdata (gold_rdata)
  );

  ssfi_cut #(.W(W), .OW(OW), .INIT(INIT), .POLY(POLY)) u_cut (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .init_en (cut_init),
    .func_en (cut_func),
    .scan_en (cut_scan),
    .scan_in (cut_scan_in),
    .stim    (stim),
    .dout    (cut_dout)
  );

  ssfi_ctrl #(
    .W(W), .OW(OW), .NCYC(NCYC), .NREC(NREC), .CW(CW), .STIM_K(STIM_K)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .rec_rdata   (rec_rdata),
    .rec_raddr   (rec_raddr),
    .gold_we     (gold_we),
    .gold_addr   (gold_addr),
    .gold_rdata  (gold_rdata),
    .cut_dout    (cut_dout),
    .cut_init    (cut_init),
    .cut_func    (cut_func),
    .cut_scan    (cut_scan),
    .cut_scan_in (cut_scan_in),
    .stim        (stim),
    .busy        (busy),
    .done        (done),
    .fail_map    (fail_map)
  );

  assign scan_active = cut_scan;

  // R9: the record store is never written during a campaign
  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !rec_wr_ok);

endmodule

// File: tb/ssfi_engine_bench.sv
module ssfi_engine_bench;

  localparam int W    = 8;
  localparam int OW   = 4;
  localparam int NCYC = 16;
  localparam int NREC = 8;
  localparam int CW   = 5;
  localparam int AW   = 3;
  localparam logic [7:0] INIT   = 8'h5A;
  localparam logic [7:0] POLY   = 8'h1D;
  localparam logic [7:0] STIM_K = 8'h13;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            rec_we;
  logic [AW-1:0]   rec_addr;
  logic [CW+W-1:0] rec_wdata;
  logic            busy, done, scan_active;
  logic [NREC-1:0] fail_map;

  int checks = 0;
  int errors = 0;

  logic [7:0] gs [NCYC];
  int         rc [NREC];
  logic [7:0] rs [NREC];

  ssfi_engine u_ssfi_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rec_we      (rec_we),
    .rec_addr    (rec_addr),
    .rec_wdata   (rec_wdata),
    .busy        (busy),
    .done        (done),
    .scan_active (scan_active),
    .fail_map    (fail_map)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R3 model of one functional step
  function automatic logic [7:0] f_next(input logic [7:0] s, input int t);
    logic [7:0] x;
    x = 8'((t * int'(STIM_K)) & 255);
    return {s[6:0], 1'b0} ^ x ^ (s[7] ? POLY : 8'h00);
  endfunction

  // R2 reference run
  function automatic void build_gold();
    logic [7:0] s;
    s = INIT;
    for (int t = 0; t < NCYC; t++) begin
      gs[t] = s;
      s = f_next(s, t);
    end
  endfunction

  // R6/R7 model of one replay: outcome and cycles spent replaying
  function automatic bit eval_rec(input int c, input logic [7:0] fs, output int run);
    logic [7:0] s;
    if (c >= NCYC) begin
      run = 1;
      return 1'b0;
    end
    s = fs;
    for (int t = c; t < NCYC; t++) begin
      if (s[3:0] != gs[t][3:0]) begin
        run = t - c + 1;
        return 1'b1;
      end
      s = f_next(s, t);
    end
    run = NCYC - c + 1;
    return 1'b0;
  endfunction

  // R5 record layout {cycle, state}
  task automatic write_rec(input int a, input int c, input logic [7:0] s);
    rec_we    = 1'b1;
    rec_addr  = AW'(a);
    rec_wdata = {CW'(c), s};
    rc[a] = c;
    rs[a] = s;
    @(negedge clk);
    rec_we = 1'b0;
  endtask

  task automatic run_campaign(input bit disturb, output int bcyc, output int wins,
                              output int badw, output logic [NREC-1:0] map0,
                              output bit hung);
    int run;
    int guard;
    bcyc = 0; wins = 0; badw = 0; run = 0; hung = 1'b0; guard = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    map0 = fail_map;
    while (!done && guard < 20000) begin
      if (busy) bcyc++;
      if (scan_active) run++;
      else if (run != 0) begin
        wins++;
        if (run != W) badw++;
        run = 0;
      end
      if (disturb && bcyc == 40) begin
        rec_we = 1'b1; rec_addr = '0; rec_wdata = '1; start = 1'b1;
      end else begin
        rec_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    rec_we = 1'b0;
    start  = 1'b0;
    if (!done) hung = 1'b1;
  endtask

  task automatic check_campaign(input string name, input bit disturb, input bit chk_clear);
    int bcyc, wins, badw, exp_b, run;
    bit hung, f;
    logic [NREC-1:0] map0, exp_map;
    exp_b = NCYC;
    exp_map = '0;
    for (int i = 0; i < NREC; i++) begin
      f = eval_rec(rc[i], rs[i], run);
      exp_map[i] = f;
      exp_b += 2 + W + run;
    end
    run_campaign(disturb, bcyc, wins, badw, map0, hung);
    chk(!hung, {name, " R8 done reached"}, hung, 0);
    if (chk_clear) chk(map0 == '0, {name, " R8 map cleared on start"}, map0, 0);
    for (int i = 0; i < NREC; i++)
      chk(fail_map[i] == exp_map[i], $sformatf("%s R6/R7 record %0d outcome", name, i),
          fail_map[i], exp_map[i]);
    chk(bcyc == exp_b, {name, " R6 R10 busy cycle count"}, bcyc, exp_b);
    chk(wins == NREC, {name, " R4 shift windows"}, wins, NREC);
    chk(badw == 0, {name, " R4 window length W"}, badw, 0);
    chk(done && !busy, {name, " R8 done high busy low"}, {done, busy}, 2'b10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; rec_we = 1'b0; rec_addr = '0; rec_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !scan_active && fail_map == '0, "R1 in reset",
        {busy, done, scan_active, fail_map}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!done, "R1 done after reset", done, 0);
    chk(!scan_active, "R1 scan_active after reset", scan_active, 0);
    chk(fail_map == '0, "R1 fail_map after reset", fail_map, 0);
  endtask

  // Mixed faults: immediate, delayed, last cycle, beyond end, no fault at all.
  task automatic t_mixed();
    write_rec(0, 2,  gs[2]  ^ 8'h01);
    write_rec(1, 5,  gs[5]  ^ 8'h80);
    write_rec(2, 15, gs[15] ^ 8'h40);
    write_rec(3, 20, 8'hFF);
    write_rec(4, 7,  gs[7]);
    write_rec(5, 0,  gs[0]  ^ 8'h10);
    write_rec(6, 10, gs[10] ^ 8'h20);
    write_rec(7, 12, gs[12] ^ 8'h08);
    check_campaign("mixed", 1'b0, 1'b1);
  endtask

  // R9 R10: writes and start during the campaign leave it undisturbed;
  // a rerun without reloading yields the same outcomes.
  task automatic t_busy_ignore();
    check_campaign("disturbed", 1'b1, 1'b0);
    check_campaign("rerun R9", 1'b0, 1'b1);
  endtask

  // R4 R5: every single-bit flip at cycle 3 exercises shift order.
  task automatic t_each_bit();
    for (int b = 0; b < W; b++) write_rec(b, 3, gs[3] ^ (8'h01 << b));
    check_campaign("each_bit", 1'b0, 1'b1);
  endtask

  initial begin
    build_gold();
    t_reset();
    t_mixed();
    t_busy_ignore();
    t_each_bit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule